// File: doc/BRIEF.md
# Random-Data Memory Self-Tester

The block tests a storage device through a plain request interface. After reset it writes a pseudo-random word to every address from 0 up to the last address. It then restarts its generator from the same seed, reads every address back in the same order, and compares each returned word with the regenerated value. No copy of the written data is kept, because the generator produces the expected word again for each position.

A 4-bit status code reports progress and is meant for a seven-segment decoder. The code shows the write phase, then the verify phase, then a pass code or an error code. A done flag and an error flag carry the final outcome. The outcome stays fixed until the next reset. The memory side uses request/accept handshakes. A write or read request stays asserted until the memory accepts it. Read data comes back with a valid strobe, and only one read is in flight at a time.

Top module: `mem_selftest`

## Requirements
- R1: While reset (synchronous, active high) is applied and in the first cycle after it, status is 4'h2, done and error are 0, memWr is 1, memAddr is 0 and memWrData equals SEED.
- R2: The write phase writes addresses 0, 1, ..., DEPTH-1 in order. The data follows the right-shift Galois sequence next = (g >> 1) ^ (g[0] ? POLY : 0), starting from SEED. Address and data advance only in a cycle where memWr and memAccept are both 1, and both hold stable while the request waits.
- R3: The status code is 4'h2 for the whole write phase and 4'h3 for the whole verify phase.
- R4: In the cycle after the last write is accepted, memRd asserts for address 0. Reads then cover the addresses in ascending order. After a read is accepted, no new request is made until memRdValid returns the data, and memRdValid must arrive at least one cycle after the accept.
- R5: Each returned word is compared with the generator value for that address position. In the verify phase the generator restarts at SEED and advances only when read data is returned.
- R6: If every comparison matches, then one cycle after the last read data the block shows status 4'h0, done 1 and error 0.
- R7: On the first mismatch, the next cycle shows status 4'hE, done 1 and error 1, and the block issues no further requests. The number of reads issued is the failing address plus one.
- R8: The final status, done and error hold unchanged until reset, whatever memAccept, memRdValid and memRdData do.
- R9: memWr and memRd are never 1 together, and neither is 1 once done is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memWr | output | 1 | Write request |
| memRd | output | 1 | Read request |
| memAddr | output | ADDR_W | Request address |
| memWrData | output | DATA_W | Write data |
| memAccept | input | 1 | Memory accepts the current request |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | DATA_W | Read data |
| status | output | 4 | Progress code: 2 write, 3 verify, 0 pass, E error |
| done | output | 1 | Test finished |
| error | output | 1 | Test failed |

## Verification
The bench builds the block with DEPTH = 32, DATA_W = 16, POLY = 16'hB400 and SEED = 16'h1D0F. With only 32 addresses, the full write/verify pass completes in a few hundred cycles, even when accepts are stalled at random and read latency varies from one to three cycles. This leaves room for several separate runs. The runs inject errors at address 0, at a middle address and at the last address, and they apply stray accept and valid strobes after the test has finished.

// File: rtl/memtest_pkg.sv
package memtest_pkg;
  typedef enum logic [3:0] {
    CODE_PASS   = 4'h0,
    CODE_WRITE  = 4'h2,
    CODE_VERIFY = 4'h3,
    CODE_FAIL   = 4'hE
  } statusCode_t;

  typedef enum logic [2:0] {
    PH_WRITE, PH_RDREQ, PH_RDWAIT, PH_PASS, PH_FAIL
  } phase_t;

  typedef struct packed {
    logic clrAddr;
    logic incAddr;
    logic loadSeed;
    logic stepGen;
  } dpCtrl_t;
endpackage

// File: rtl/memtest_datapath.sv
module memtest_datapath
  import memtest_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] SEED = 16'hACE1,
  parameter logic [DATA_W-1:0] POLY = 16'hB400,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] genWord,
  output logic              isLast,
  output logic              match
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] genNext;

  always_comb begin
    genNext = (genWord >> 1) ^ (genWord[0] ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      genWord <= SEED;
    end else begin
      if (ctrl.clrAddr)      addr <= '0;
      else if (ctrl.incAddr) addr <= addr + 1'b1;
      if (ctrl.loadSeed)     genWord <= SEED;
      else if (ctrl.stepGen) genWord <= genNext;
    end
  end

  assign isLast = (addr == LAST_ADDR);
  assign match  = (rdData == genWord);
endmodule

// File: rtl/memtest_control.sv
module memtest_control
  import memtest_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    accept,
  input  logic    rdValid,
  input  logic    isLast,
  input  logic    match,
  output dpCtrl_t ctrl,
  output logic    wrReq,
  output logic    rdReq,
  output logic [3:0] statusCode,
  output logic    doneFlag,
  output logic    errFlag
);
  phase_t phase, phaseNext;

  always_comb begin
    ctrl       = '0;
    wrReq      = 1'b0;
    rdReq      = 1'b0;
    phaseNext  = phase;
    statusCode = CODE_WRITE;
    doneFlag   = 1'b0;
    errFlag    = 1'b0;
    case (phase)
      PH_WRITE: begin
        wrReq = 1'b1;
        if (accept) begin
          ctrl.stepGen = 1'b1;
          if (isLast) begin
            ctrl.clrAddr  = 1'b1;
            ctrl.loadSeed = 1'b1;
            phaseNext     = PH_RDREQ;
          end else begin
            ctrl.incAddr = 1'b1;
          end
        end
      end
      PH_RDREQ: begin
        statusCode = CODE_VERIFY;
        rdReq      = 1'b1;
        if (accept) phaseNext = PH_RDWAIT;
      end
      PH_RDWAIT: begin
        statusCode = CODE_VERIFY;
        if (rdValid) begin
          if (!match)      phaseNext = PH_FAIL;
          else if (isLast) phaseNext = PH_PASS;
          else begin
            ctrl.incAddr = 1'b1;
            ctrl.stepGen = 1'b1;
            phaseNext    = PH_RDREQ;
          end
        end
      end
      PH_PASS: begin
        statusCode = CODE_PASS;
        doneFlag   = 1'b1;
      end
      default: begin
        statusCode = CODE_FAIL;
        doneFlag   = 1'b1;
        errFlag    = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_WRITE;
    else     phase <= phaseNext;
  end
endmodule

// File: rtl/mem_selftest.sv
module mem_selftest
  import memtest_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] SEED = 16'hACE1,
  parameter logic [DATA_W-1:0] POLY = 16'hB400,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic              memWr,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memAccept,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic [3:0]        status,
  output logic              done,
  output logic              error
);
  dpCtrl_t ctrl;
  logic isLast, match;

  memtest_control u_ctrl (
    .clk(clk), .rst(rst), .accept(memAccept), .rdValid(memRdValid),
    .isLast(isLast), .match(match), .ctrl(ctrl), .wrReq(memWr),
    .rdReq(memRd), .statusCode(status), .doneFlag(done), .errFlag(error)
  );

  memtest_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SEED(SEED), .POLY(POLY)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .rdData(memRdData),
    .addr(memAddr), .genWord(memWrData), .isLast(isLast), .match(match)
  );
endmodule

// File: rtl/mem_selftest_chk.sv
module mem_selftest_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              memWr,
  input logic              memRd,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic              memAccept,
  input logic              memRdValid,
  input logic [3:0]        status,
  input logic              done,
  input logic              error
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(memWr && memRd)); // R9
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    memWr && !memAccept |=> memWr && $stable(memAddr) && $stable(memWrData)); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    memRd && !memAccept |=> memRd && $stable(memAddr)); // R4
  AST_RD_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    memRd && memAccept |=> !memRd && !memWr); // R4
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    status == 4'h2 || status == 4'h3 || status == 4'h0 || status == 4'hE); // R3
  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (rst) done |-> !memWr && !memRd); // R9
  AST_ERROR_IS_DONE: assert property (@(posedge clk) disable iff (rst) error |-> done && status == 4'hE); // R7
  AST_FINAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    done |=> done && $stable(status) && $stable(error)); // R8
endmodule

bind mem_selftest mem_selftest_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .memWr(memWr), .memRd(memRd), .memAddr(memAddr),
  .memWrData(memWrData), .memAccept(memAccept), .memRdValid(memRdValid),
  .status(status), .done(done), .error(error)
);

// File: tb/mem_selftest_tb.sv
module mem_selftest_tb;
  localparam int DEPTH = 32;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam logic [DW-1:0] SEED = 16'h1D0F;
  localparam logic [DW-1:0] POLY = 16'hB400;

  logic clk = 0, rst = 1;
  logic memWr, memRd, memAccept = 0, memRdValid = 0, done, error;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWrData, memRdData = '0;
  logic [3:0] status;

  always #2.5 clk = ~clk;

  mem_selftest #(.DEPTH(DEPTH), .DATA_W(DW), .SEED(SEED), .POLY(POLY)) u_dut (.*);

  int checks = 0, errors = 0;
  int mPhase, mIdx, rdCnt, rdAddr, rdIssued, stallMode, badAddr;
  logic [DW-1:0] mGen, badMask;
  logic [DW-1:0] mem [DEPTH];

  function automatic logic [DW-1:0] stepGen(logic [DW-1:0] g);
    return (g >> 1) ^ (g[0] ? POLY : '0);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] expStatus(int ph);
    case (ph)
      0: return 4'h2;
      1, 2: return 4'h3;
      3: return 4'h0;
      default: return 4'hE;
    endcase
  endfunction

  // Per-cycle reference comparison and memory device model
  always @(negedge clk) begin
    if (!rst) begin
      logic acc, rv;
      logic [DW-1:0] rdat;
      chk(memWr == (mPhase == 0), "R2", "memWr", memWr, mPhase == 0);
      chk(memRd == (mPhase == 1), "R4", "memRd", memRd, mPhase == 1);
      chk(status == expStatus(mPhase), "R3", "status", status, expStatus(mPhase));
      chk(done == (mPhase >= 3) && error == (mPhase == 4), "R6", "done/error",
          {done, error}, {mPhase >= 3, mPhase == 4});
      if (mPhase <= 1) chk(memAddr == mIdx, "R4", "memAddr", memAddr, mIdx);
      if (mPhase == 0) chk(memWrData == mGen, "R2", "memWrData", memWrData, mGen);

      acc  = (stallMode == 0) ? 1'b1 : ($urandom % 3 != 0);
      rv   = 1'b0;
      rdat = $urandom;
      if (rdCnt > 0) begin
        rdCnt--;
        if (rdCnt == 0) begin
          rv = 1'b1;
          rdat = mem[rdAddr] ^ ((rdAddr == badAddr) ? badMask : '0);
        end
      end
      if (mPhase >= 3) begin  // stray strobes after finish, R8
        acc = $urandom;
        rv  = $urandom;
      end

      if (memWr && acc) mem[memAddr] = memWrData;
      case (mPhase)
        0: if (acc) begin
             mGen = stepGen(mGen);
             if (mIdx == DEPTH - 1) begin mPhase = 1; mIdx = 0; mGen = SEED; end
             else mIdx++;
           end
        1: if (acc) begin
             mPhase = 2; rdAddr = mIdx; rdIssued++;
             rdCnt = (stallMode == 0) ? 1 : 1 + $urandom % 3;
           end
        2: if (rv) begin
             if (rdat != mGen) mPhase = 4;
             else if (mIdx == DEPTH - 1) mPhase = 3;
             else begin mIdx++; mGen = stepGen(mGen); mPhase = 1; end
           end
        default: ;
      endcase
      memAccept  <= acc;
      memRdValid <= rv;
      memRdData  <= rdat;
    end
  end

  task automatic runTest(int stall, int bad, logic [DW-1:0] mask, string tag);
    stallMode = stall; badAddr = bad; badMask = mask;
    rst = 1; memAccept = 0; memRdValid = 0;
    mPhase = 0; mIdx = 0; mGen = SEED; rdCnt = 0; rdIssued = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk); #0.1;
    // R1: first cycle after reset
    chk(status == 4'h2 && !done && !error, "R1", "reset status/done/error",
        {status, done, error}, {4'h2, 2'b00});
    chk(memWr && memAddr == 0 && memWrData == SEED, "R1", "first write",
        {memWr, memAddr, memWrData}, {1'b1, 5'd0, SEED});
    for (int i = 0; i < 5000 && mPhase < 3; i++) @(negedge clk);
    if (mPhase < 3) chk(0, "R6", {"watchdog ", tag}, mPhase, 3);
    repeat (20) @(negedge clk);
    #0.1;
    if (bad < 0) begin
      chk(status == 4'h0 && done && !error, "R6", {"pass outcome ", tag},
          {status, done, error}, {4'h0, 2'b10});
    end else begin
      chk(status == 4'hE && done && error, "R7", {"fail outcome ", tag},
          {status, done, error}, {4'hE, 2'b11});
      chk(rdIssued == bad + 1, "R7", {"reads before stop ", tag}, rdIssued, bad + 1);
    end
    chk(!memWr && !memRd, "R8", {"quiet after finish ", tag}, {memWr, memRd}, 0);
  endtask

  initial begin
    runTest(0, -1, '0, "clean");        // R2 R3 R4 R5 R6
    runTest(1, -1, '0, "stalled");      // R2 R4 R5 under stalls
    runTest(1, 7, 16'h0100, "mid");     // R7 middle address
    runTest(0, 0, 16'h0001, "first");   // R7 address 0
    runTest(1, DEPTH - 1, 16'h8000, "last"); // R7 last address
    runTest(0, -1, '0, "again");        // R8 reset clears final state
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    errors++;
    $display("FAIL R6 global watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule